// File: doc/BRIEF.md
# Phase-Staggered Multi-Channel PWM Bank

This block drives a large set of pulse-width-modulated outputs from one shared period counter. Each channel holds its own duty value, loaded by a host through a small write port (channel address, data, write strobe). That port would normally sit behind a serial host bridge. Each channel goes high at the start of its period and stays high for as many clock cycles as its duty value.

Channels are split into fixed groups of consecutive indices. Each group sees the counter delayed by its group number. Group g therefore starts its period g clock cycles after group 0. Only one group's outputs can make their turn-on transition on any clock edge. This bounds the number of simultaneously switching outputs to the group size and so limits ground bounce.

A new duty value first lands in a per-channel holding register. It is adopted only when that channel's next period begins, so a running period is never cut short or lengthened.

Top module: `pwmb_bank`

## Requirements
- R1: On any single clock edge, at most GRP outputs (default 8) change from low to high.
- R2: A channel whose duty value is d, with 0 < d < 2^CW, is high for exactly d consecutive cycles of every 2^CW-cycle period. The high time starts at the channel's period start.
- R3: One free-running CW-bit counter (default 8) sets the period, so every channel's period start repeats every 2^CW cycles.
- R4: A duty value of 0 keeps the output low for the whole period. Any duty value of 2^CW or more keeps it high for the whole period, and it does not drop at the period boundary.
- R5: Channel c belongs to group c / GRP (integer division). All channels of group g rise on the same edge, which comes g cycles (modulo 2^CW) after the rising edge of group 0.
- R6: A write with wr_en high and wr_addr = c loads wr_data (CW+1 bits, unsigned) into channel c. The value takes effect at channel c's next period start, and the period already running keeps its old length.
- R7: A write to an address of NUM_CH or above changes no channel's output.
- R8: While rst_n is low, all outputs are low, all duty values are 0 and the counter is 0. Group 0 starts its first period on the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Duty write strobe |
| wr_addr | input | AW = clog2(NUM_CH) | Channel index of the write |
| wr_data | input | CW+1 | Duty value in clock cycles |
| pwm | output | NUM_CH | One PWM output per channel |

## Verification
The hardest case to reach from the ports is a duty write that lands in the middle of a running period. It must leave that period's pulse untouched and change only the next one. The stimulus first waits for a rising edge of channel 0 while it runs a known duty. It then writes a new duty ten cycles into the pulse and measures the widths of that pulse and the following pulse edge to edge. The stagger is checked the same way: every channel gets the same duty, and the bench records on which edge each channel first rises relative to channel 0. A monitor counts low-to-high transitions on every edge throughout the run.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

  // Number of groups needed to hold n channels in groups of size g.
  function automatic int unsigned ceil_div(int unsigned n, int unsigned g);
    return (n + g - 1) / g;
  endfunction

endpackage

// File: rtl/pwmb_counter.sv
module pwmb_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_d;
  end

endmodule

// File: rtl/pwmb_decode.sv
module pwmb_decode #(
  parameter int NUM_CH = 80,
  parameter int AW     = 7
) (
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  output logic [NUM_CH-1:0] sel_o
);

  // Addresses at or above NUM_CH match no lane and are dropped.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      sel_o[c] = wr_en_i && (addr_i == AW'(c));
    end
  end

endmodule

// File: rtl/pwmb_group.sv
module pwmb_group #(
  parameter int CW     = 8,
  parameter int LANES  = 8,
  parameter int OFFSET = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cnt_i,
  input  logic [LANES-1:0] wr_en_i,
  input  logic [CW:0]      wr_data_i,
  output logic [LANES-1:0] pwm_o
);

  logic [CW-1:0]    phase;
  logic             start;
  logic [CW:0]      shadow_q [LANES];
  logic [CW:0]      shadow_d [LANES];
  logic [CW:0]      active_q [LANES];
  logic [CW:0]      active_d [LANES];
  logic [LANES-1:0] pwm_d;

  // Local phase: the shared counter delayed by this group's offset.
  always_comb begin
    phase = cnt_i - CW'(OFFSET);
    start = (phase == '0);
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      shadow_d[i] = wr_data_i;
      active_d[i] = start ? shadow_q[i] : active_q[i];
      pwm_d[i]    = ({1'b0, phase} < active_d[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end
      pwm_o <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_en_i[i]) shadow_q[i] <= shadow_d[i];
        if (start)      active_q[i] <= active_d[i];
      end
      pwm_o <= pwm_d;
    end
  end

endmodule

// File: rtl/pwmb_bank.sv
module pwmb_bank #(
  parameter int NUM_CH = 80,
  parameter int GRP    = 8,
  parameter int CW     = 8,
  localparam int AW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW:0]       wr_data,
  output logic [NUM_CH-1:0] pwm
);

  localparam int NGRP = int'(pwmb_pkg::ceil_div(NUM_CH, GRP));

  logic [CW-1:0]     cnt;
  logic [NUM_CH-1:0] wr_sel;

  pwmb_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (cnt)
  );

  pwmb_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .wr_en_i (wr_en),
    .addr_i  (wr_addr),
    .sel_o   (wr_sel)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = g * GRP;
    localparam int L  = ((NUM_CH - LO) < GRP) ? (NUM_CH - LO) : GRP;
    pwmb_group #(
      .CW     (CW),
      .LANES  (L),
      .OFFSET (g % (2 ** CW))
    ) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_i     (cnt),
      .wr_en_i   (wr_sel[LO +: L]),
      .wr_data_i (wr_data),
      .pwm_o     (pwm[LO +: L])
    );
  end

endmodule

// File: rtl/pwmb_chk.sv
module pwmb_chk #(
  parameter int NUM_CH = 80,
  parameter int GRP    = 8,
  parameter int CW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] pwm,
  input logic [CW-1:0]     cnt
);

  localparam int NGRP = int'(pwmb_pkg::ceil_div(NUM_CH, GRP));

  // R1: bounded simultaneous turn-on
  a_r1_rise_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwm & ~$past(pwm)) <= GRP)
    else $error("a_r1_rise_limit");

  // R3: shared counter advances by one each cycle
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cnt == CW'($past(cnt) + CW'(1))))
    else $error("a_r3_count_step");

  // R8: reset holds outputs and counter at zero
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_low: assert (pwm == '0 && cnt == '0)
        else $error("a_r8_reset_low");
    end
  end

  // R5: a group rises only right after its own period start
  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    localparam int LO = g * GRP;
    localparam int L  = ((NUM_CH - LO) < GRP) ? (NUM_CH - LO) : GRP;
    a_r5_group_start: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pwm[LO +: L] & ~$past(pwm[LO +: L]))) |-> (cnt == CW'((g + 1) % (2 ** CW))))
      else $error("a_r5_group_start");
  end

endmodule

bind pwmb_bank pwmb_chk #(.NUM_CH(NUM_CH), .GRP(GRP), .CW(CW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .pwm   (pwm),
  .cnt   (cnt)
);

// File: tb/sim_pwmb_bank.sv
module sim_pwmb_bank;

  localparam int NUM_CH = 80;
  localparam int GRP    = 8;
  localparam int CW     = 8;
  localparam int AW     = $clog2(NUM_CH);
  localparam int PER    = 2 ** CW;
  localparam int NVEC   = 12;
  // {channel address, duty}
  localparam logic [15:0] VEC [NVEC] = '{
    {7'd0, 9'd1},    {7'd1, 9'd255},  {7'd9, 9'd128},  {7'd17, 9'd3},
    {7'd23, 9'd200}, {7'd40, 9'd64},  {7'd47, 9'd100}, {7'd55, 9'd17},
    {7'd63, 9'd2},   {7'd71, 9'd250}, {7'd72, 9'd77},  {7'd79, 9'd130}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [CW:0]       wr_data = '0;
  logic [NUM_CH-1:0] pwm;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  int exp_d [NUM_CH];

  logic [NUM_CH-1:0] prev_m;
  int rise_now = 0;
  int max_rise = 0;
  int rise_viol = 0;

  pwmb_bank #(.NUM_CH(NUM_CH), .GRP(GRP), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm(pwm)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc++;

  // Turn-on transitions per edge (R1)
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_m = '0;
    end else begin
      rise_now = $countones(pwm & ~prev_m);
      if (rise_now > max_rise) max_rise = rise_now;
      if (rise_now > GRP) rise_viol++;
      prev_m = pwm;
    end
  end

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(int addr, int data);
    wr_addr = AW'(addr);
    wr_data = (CW+1)'(data);
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    if (addr < NUM_CH) exp_d[addr] = data;
  endtask

  function automatic int hi_cycles(int d);
    return (d >= PER) ? PER : d;
  endfunction

  // Count high samples of every channel over one full period.
  task automatic window(string req);
    int hi [NUM_CH];
    for (int c = 0; c < NUM_CH; c++) hi[c] = 0;
    for (int k = 0; k < PER; k++) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) hi[c] += int'(pwm[c]);
    end
    for (int c = 0; c < NUM_CH; c++)
      chk($sformatf("%s ch%0d", req, c), hi[c], hi_cycles(exp_d[c]));
  endtask

  task automatic wait_val(int ch, logic v, output int t);
    t = -1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (pwm[ch] == v) begin
        t = cyc;
        break;
      end
    end
    if (t < 0) chk($sformatf("wait ch%0d=%0d", ch, v), 0, 1);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int t0, tr, tf, tr2, tf2, bad5, bad6, hi7;
    int first [NUM_CH];
    for (int c = 0; c < NUM_CH; c++) exp_d[c] = 0;
    #1 rst_n = 1'b0;

    // R8: outputs low during reset
    repeat (4) @(negedge clk);
    chk("R8 outputs low in reset", int'(pwm != '0), 0);
    rst_n = 1'b1;

    // R8/R4: duties zero after reset, outputs stay low
    bad6 = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (pwm != '0) bad6++;
    end
    chk("R8 R4 low after reset", bad6, 0);

    // R2/R6: table of duty vectors
    for (int v = 0; v < NVEC; v++) wr(int'(VEC[v][15:9]), int'(VEC[v][8:0]));
    repeat (2 * PER + 16) @(negedge clk);
    window("R2 table");

    // R7: out-of-range writes ignored
    wr(80, 300);
    wr(127, 511);
    wr(100, 5);
    repeat (2 * PER + 16) @(negedge clk);
    window("R7 ignore");

    // R4: full, zero and one-short-of-full duty
    wr(5, 256);
    wr(6, 0);
    wr(7, 255);
    wr(9, 511);
    repeat (2 * PER + 16) @(negedge clk);
    bad5 = 0; bad6 = 0; hi7 = 0;
    for (int k = 0; k < PER + 40; k++) begin
      @(negedge clk);
      if (!pwm[5] || !pwm[9]) bad5++;
      if (pwm[6]) bad6++;
      if (k < PER) hi7 += int'(pwm[7]);
    end
    chk("R4 full duty never low", bad5, 0);
    chk("R4 zero duty never high", bad6, 0);
    chk("R2 duty 255 high time", hi7, 255);

    // R5/R3/R1: equal duties, measure stagger of the rises
    for (int c = 0; c < NUM_CH; c++) wr(c, 128);
    repeat (2 * PER + 16) @(negedge clk);
    wait_val(0, 1'b0, tf);
    wait_val(0, 1'b1, t0);
    for (int c = 0; c < NUM_CH; c++) first[c] = pwm[c] ? t0 : -1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++)
        if (first[c] < 0 && pwm[c]) first[c] = cyc;
    end
    for (int c = 0; c < NUM_CH; c++)
      chk($sformatf("R5 rise offset ch%0d", c), first[c] - t0, c / GRP);
    window("R2 equal duty");
    chk("R1 rises per edge equal group size", max_rise, GRP);

    // R6/R3: write mid-pulse on channel 0
    wait_val(0, 1'b0, tf);
    wait_val(0, 1'b1, tr);
    repeat (10) @(negedge clk);
    wr(0, 20);
    wait_val(0, 1'b0, tf);
    chk("R6 running pulse unchanged", tf - tr, 128);
    wait_val(0, 1'b1, tr2);
    chk("R3 period length", tr2 - tr, PER);
    wait_val(0, 1'b0, tf2);
    chk("R6 new duty next period", tf2 - tr2, 20);

    chk("R1 rise limit violations", rise_viol, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule